// File: doc/BRIEF.md
# GPIO Bank with Pull Control

This block is a register-mapped bank of general-purpose pins, up to 32 of them. Each pin has five controls: a direction bit, an output level, a pull enable, a pull direction and a sampled input level. Software reaches them through a small word-addressed register port with separate read and write strobes. On the pad side the bank drives an output level, an active-low output enable and separate pull-up and pull-down requests for each pin. It samples the pad levels through a two-flop synchronizer.

Two parameters set the bank's shape. `NUM_PINS` sets the pin count. `FIELD_SHIFT` moves the output-level and pull-direction fields up inside their registers. The shift is for the always-on flavour of the bank, where pin `i` of those two fields sits at bit `i+FIELD_SHIFT`. The direction, input and pull-enable fields always keep pin `i` at bit `i`. `NUM_PINS + FIELD_SHIFT` must not exceed 32.

Register word addresses are fixed:

| Address | Field | Pin `i` at bit | Access |
|---------|-------|----------------|--------|
| 0 | direction | `i` | read/write |
| 1 | output level | `i+FIELD_SHIFT` | read/write |
| 2 | input level | `i` | read-only |
| 3 | pull enable | `i` | read/write |
| 4 | pull direction | `i+FIELD_SHIFT` | read/write |
| 5 to 7 | unmapped | none | none |

Top module: `gpio_bank`

## Requirements
- R1: While reset is held, every pin reads as an input. `pad_oe_no` is all ones, and `pad_out_o`, `pad_pu_o`, `pad_pd_o` and `rdata_o` are all zero.
- R2: The direction register is at address 0, with pin i at bit i. A 0 in that bit drives `pad_oe_no[i]` low, which makes the pin an output. A 1 makes the pin an input.
- R3: The output register is at address 1. Bit i+FIELD_SHIFT drives `pad_out_o[i]`.
- R4: The pull-enable register is at address 3, with pin i at bit i. When that bit is 0, neither `pad_pu_o[i]` nor `pad_pd_o[i]` is asserted.
- R5: When pull is enabled, a pull-direction bit of 1 asserts `pad_pu_o[i]` only, and a bit of 0 asserts `pad_pd_o[i]` only.
- R6: The pull-direction register is at address 4, with pin i at bit i+FIELD_SHIFT.
- R7: The input register is at address 2. It returns the synchronized pad level of pin i at bit i. Writes to it change nothing.
- R8: A pad level present before clock edge k is returned by a read strobed at edge k+2 or later. It is not yet visible to a read strobed at edge k or k+1.
- R9: Register bits that no pin maps to are ignored on write and read as 0. These are bits at or above NUM_PINS in the direction, input and pull-enable registers, and bits outside FIELD_SHIFT to FIELD_SHIFT+NUM_PINS-1 in the output and pull-direction registers.
- R10: A write takes effect at the clock edge that samples `wr_en_i`. A read loads `rdata_o` at the edge that samples `rd_en_i`, using the register values from before that edge. `rdata_o` then holds until the next read.
- R11: Addresses 5 to 7 are unmapped. Writes to them change no state, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| pad_in_i | input | NUM_PINS | Asynchronous pad input levels |
| pad_out_o | output | NUM_PINS | Output level to the pads |
| pad_oe_no | output | NUM_PINS | Output enable to the pads, active low |
| pad_pu_o | output | NUM_PINS | Pull-up request |
| pad_pd_o | output | NUM_PINS | Pull-down request |

## Verification
Two cases are hard to reach from the ports.

The first is the synchronizer latency seen through the register port. A pad change only shows up through a read of address 2, so the timing can only be seen by lining up reads with pad changes. The stimulus changes the pad levels and then reads the input register on each of the following cycles. The bench model tracks both synchronizer stages, so a read that comes one cycle too early or too late is reported.

The second is the shifted field layout. Only a write pattern whose bits straddle the field edges shows whether the output and pull-direction fields sit at the right offset. The stimulus writes all ones and walking patterns to every address, including the unmapped ones, and then reads each register back. Random traffic then mixes reads and writes to the same address in the same cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned AW = 3;
  localparam int unsigned DW = 32;

  typedef enum logic [AW-1:0] {
    SEL_DIR  = 3'd0,
    SEL_OUT  = 3'd1,
    SEL_IN   = 3'd2,
    SEL_PEN  = 3'd3,
    SEL_PDIR = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_field_reg.sv
module gpio_field_reg #(
  parameter logic [31:0] MASK      = 32'hFFFF_FFFF,
  parameter logic [31:0] RST_VALUE = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] q_o
);
  logic [31:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RST_VALUE & MASK;
    else if (we_i) q <= wdata_i & MASK;
  end

  assign q_o = q;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned NUM_PINS    = 12,
  parameter int unsigned FIELD_SHIFT = 16
) (
  input  logic [31:0]         dir_i,
  input  logic [31:0]         out_i,
  input  logic [31:0]         pen_i,
  input  logic [31:0]         pdir_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_no,
  output logic [NUM_PINS-1:0] pad_pu_o,
  output logic [NUM_PINS-1:0] pad_pd_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign pad_oe_no[i] = dir_i[i];
    assign pad_out_o[i] = out_i[i+FIELD_SHIFT];
    assign pad_pu_o[i]  = pen_i[i] &  pdir_i[i+FIELD_SHIFT];
    assign pad_pd_o[i]  = pen_i[i] & ~pdir_i[i+FIELD_SHIFT];
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 12,
  parameter int unsigned FIELD_SHIFT = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_no,
  output logic [NUM_PINS-1:0] pad_pu_o,
  output logic [NUM_PINS-1:0] pad_pd_o
);
  localparam logic [DW-1:0] LO_MASK = (NUM_PINS >= DW) ? {DW{1'b1}}
                                      : ((DW'(1) << NUM_PINS) - DW'(1));
  localparam logic [DW-1:0] HI_MASK = LO_MASK << FIELD_SHIFT;

  logic [DW-1:0] dir_q, out_q, pen_q, pdir_q, in_w, rd_mux, rdata_q;
  logic [NUM_PINS-1:0] sync_w;
  logic we_dir, we_out, we_pen, we_pdir;

  assign we_dir  = wr_en_i && (addr_i == SEL_DIR);
  assign we_out  = wr_en_i && (addr_i == SEL_OUT);
  assign we_pen  = wr_en_i && (addr_i == SEL_PEN);
  assign we_pdir = wr_en_i && (addr_i == SEL_PDIR);

  gpio_field_reg #(.MASK(LO_MASK), .RST_VALUE(LO_MASK)) u_dir (
    .clk_i, .rst_ni, .we_i(we_dir), .wdata_i, .q_o(dir_q));
  gpio_field_reg #(.MASK(HI_MASK), .RST_VALUE('0)) u_out (
    .clk_i, .rst_ni, .we_i(we_out), .wdata_i, .q_o(out_q));
  gpio_field_reg #(.MASK(LO_MASK), .RST_VALUE('0)) u_pen (
    .clk_i, .rst_ni, .we_i(we_pen), .wdata_i, .q_o(pen_q));
  gpio_field_reg #(.MASK(HI_MASK), .RST_VALUE('0)) u_pdir (
    .clk_i, .rst_ni, .we_i(we_pdir), .wdata_i, .q_o(pdir_q));

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(sync_w));

  assign in_w = DW'(sync_w);

  gpio_pad_ctrl #(.NUM_PINS(NUM_PINS), .FIELD_SHIFT(FIELD_SHIFT)) u_pad (
    .dir_i(dir_q), .out_i(out_q), .pen_i(pen_q), .pdir_i(pdir_q),
    .pad_out_o, .pad_oe_no, .pad_pu_o, .pad_pd_o);

  always_comb begin
    unique case (addr_i)
      SEL_DIR:  rd_mux = dir_q;
      SEL_OUT:  rd_mux = out_q;
      SEL_IN:   rd_mux = in_w;
      SEL_PEN:  rd_mux = pen_q;
      SEL_PDIR: rd_mux = pdir_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  AST_PULL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_pu_o | pad_pd_o) & ~pen_q[NUM_PINS-1:0]) == '0); // R4
  AST_PULL_UP_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pen_q[NUM_PINS-1:0] & pdir_q[FIELD_SHIFT +: NUM_PINS]) & ~pad_pu_o) == '0); // R5
  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_dir |=> (dir_q == ($past(wdata_i) & LO_MASK))); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dir_q | pen_q) & ~LO_MASK) == '0 && ((out_q | pdir_q) & ~HI_MASK) == '0); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R10
endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  localparam int N = 12;
  localparam int S = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe_n, pad_pu, pad_pd;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_no(pad_oe_n), .pad_pu_o(pad_pu), .pad_pd_o(pad_pd));

  // behavioural reference state, one entry per pin
  bit m_dir[N], m_out[N], m_pen[N], m_pdir[N], m_s1[N], m_s2[N];
  logic [31:0] m_rdata;
  string m_rtag = "R10";

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_dir[i] = 1; m_out[i] = 0; m_pen[i] = 0; m_pdir[i] = 0;
        m_s1[i] = 0; m_s2[i] = 0;
      end
      m_rdata = '0;
    end else begin
      if (rd_en) begin
        m_rdata = '0;
        for (int i = 0; i < N; i++) begin
          case (addr)
            3'd0: m_rdata[i]   = m_dir[i];
            3'd1: m_rdata[i+S] = m_out[i];
            3'd2: m_rdata[i]   = m_s2[i];
            3'd3: m_rdata[i]   = m_pen[i];
            3'd4: m_rdata[i+S] = m_pdir[i];
            default: ;
          endcase
        end
        case (addr)
          3'd1: m_rtag = "R3";
          3'd2: m_rtag = "R7/R8";
          3'd4: m_rtag = "R6";
          3'd5, 3'd6, 3'd7: m_rtag = "R11";
          default: m_rtag = "R10";
        endcase
      end
      if (wr_en) begin
        for (int i = 0; i < N; i++) begin
          case (addr)
            3'd0: m_dir[i]  = wdata[i];
            3'd1: m_out[i]  = wdata[i+S];
            3'd3: m_pen[i]  = wdata[i];
            3'd4: m_pdir[i] = wdata[i+S];
            default: ;
          endcase
        end
      end
      for (int i = 0; i < N; i++) begin
        m_s2[i] = m_s1[i];
        m_s1[i] = pad_in[i];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] e_oe, e_out, e_pu, e_pd;
      for (int i = 0; i < N; i++) begin
        e_oe[i]  = m_dir[i];
        e_out[i] = m_out[i];
        e_pu[i]  = m_pen[i] & m_pdir[i];
        e_pd[i]  = m_pen[i] & ~m_pdir[i];
      end
      check("R2 pad_oe_no", 32'(pad_oe_n), 32'(e_oe));
      check("R3 pad_out_o", 32'(pad_out), 32'(e_out));
      check("R4/R5 pad_pu_o", 32'(pad_pu), 32'(e_pu));
      check("R4/R5 pad_pd_o", 32'(pad_pd), 32'(e_pd));
      check({m_rtag, " rdata_o (R9)"}, rdata, m_rdata);
    end
  end

  task automatic step(bit w, bit r, logic [2:0] a, logic [31:0] d);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 pad_oe_no", 32'(pad_oe_n), 32'((1 << N) - 1));
    check("R1 pad_out_o", 32'(pad_out), 32'h0);
    check("R1 pulls", 32'(pad_pu | pad_pd), 32'h0);
    check("R1 rdata_o", rdata, 32'h0);
    rst_n = 1;
    @(posedge clk); #1;
    // R9 all-ones into every address, then read back
    for (int a = 0; a < 8; a++) step(1, 0, 3'(a), 32'hFFFF_FFFF);
    for (int a = 0; a < 8; a++) step(0, 1, 3'(a), '0);
    // R5 pull direction patterns; R4 disable pulls
    step(1, 0, 3'd4, 32'hA5A5_A5A5);
    step(1, 0, 3'd3, 32'h0000_0F0F);
    step(0, 1, 3'd4, '0);
    step(1, 0, 3'd3, 32'h0);
    // R2/R3 drive outputs with walking patterns
    for (int i = 0; i < 32; i++) begin
      step(1, 0, 3'd1, 32'h1 << i);
      step(1, 1, 3'd0, ~(32'h1 << i));
    end
    // R7 write to input register has no effect; R8 sync latency
    step(1, 0, 3'd2, 32'hFFFF_FFFF);
    pad_in = 12'hABC;
    for (int k = 0; k < 4; k++) step(0, 1, 3'd2, '0);
    pad_in = 12'h5A3;
    for (int k = 0; k < 4; k++) step(0, 1, 3'd2, '0);
    // R11 unmapped writes then read everything
    step(1, 0, 3'd6, 32'h1234_5678);
    for (int a = 0; a < 8; a++) step(0, 1, 3'(a), '0);
    // R10 random mixed traffic, including read and write in one cycle
    for (int k = 0; k < 2000; k++) begin
      if (($urandom % 4) == 0) pad_in = N'($urandom);
      step(1'($urandom), 1'($urandom), 3'($urandom), $urandom);
    end
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule